// File: doc/BRIEF.md
# Display PHY clock post-divider tree

This block turns a fast VCO clock into two slower clocks for a display serial link: a byte clock for the lane logic and a pixel clock for the video pipeline. The VCO passes first through an output divider whose ratio is a power of two. A one-based bit divider follows it and yields the bit clock. The byte clock is always the bit clock divided by eight. The pixel clock comes from a four-way tap selector followed by its own one-based divider.

Every derived clock is a single-cycle clock enable in the VCO domain, so downstream logic runs on the VCO clock and qualifies its registers with `byte_ce` or `pix_ce`. Each divider takes a new ratio only when it completes a period, and the pixel tap selector changes only when the pixel divider completes a period. A period in progress therefore always finishes with the settings it started with. A global enable bit gates both outputs without stopping the dividers.

Top module: `dphy_clk_post_div`

## Requirements
- R1: `od_code` selects the output divider ratio as a power of two: code 0, 1, 2 and 3 divide the VCO by 1, 2, 4 and 8.
- R2: The bit divider ratio is `cfg0[3:0]` read as a one-based count, so code N divides by N. Code 0 divides by 1.
- R3: `byte_ce` pulses for one cycle every 8 bit-clock periods, which is every O·B·8 VCO cycles, where O is the output ratio and B the bit ratio.
- R4: `cfg1[1:0]` picks the pixel tap. 0 is the bit clock (O·B), 1 is the half bit clock (O·B·2), 2 is the output-divider clock (O), and 3 is the output-divider clock divided by 4 (O·4).
- R5: The pixel divider ratio is `cfg0[7:4]` read one-based, with 0 treated as 1. `pix_ce` pulses once every P taps of the selected source.
- R6: `cfg1[5]` is a registered global enable. From the cycle after it is sampled low, both outputs stay low. The dividers keep counting while it is low, and pulses resume once it is high again.
- R7: A new pixel select or pixel ratio takes effect only when the pixel divider completes a period. A pixel period already under way ends with its old tap and ratio.
- R8: Reset puts every divider at zero phase with ratio 1, and both outputs are low during reset. The first `byte_ce` after release falls in the cycle that follows the (7·O·B)-th rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| od_code | input | 2 | Output divider power-of-two code |
| cfg0 | input | 8 | Bit divider [3:0], pixel divider [7:4] |
| cfg1 | input | 8 | Pixel tap select [1:0], global enable [5] |
| byte_ce | output | 1 | Byte clock enable pulse |
| pix_ce | output | 1 | Pixel clock enable pulse |

## Verification
The bench sweeps every output code against every pixel tap, with bit and pixel codes that include zero, one and larger values. It measures settled pulse spacing on both outputs and compares it with the product of the ratios. A design that read zero codes literally would overflow or stall. A design that swapped two tap indices would show the wrong pixel spacing for exactly those selects. The bench also changes the pixel tap and ratio halfway through a period: a design that applied settings at once would cut that period short. Further checks time the first byte pulse after reset, which catches a wrong reset phase, and confirm that a low enable blocks all pulses but that pulses resume afterwards.

// File: rtl/dphy_clk_post_div.sv
module dphy_clk_post_div #(
  parameter int ODW  = 2,
  parameter int DIVW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ODW-1:0]    od_code,
  input  logic [2*DIVW-1:0] cfg0,
  input  logic [2*DIVW-1:0] cfg1,
  output logic              byte_ce,
  output logic              pix_ce
);
  localparam int OCW = (1 << ODW) - 1;
  localparam int ENB = 5;

  logic [OCW-1:0]  od_cnt, od_lim, od_nx;
  logic [DIVW-1:0] b_cnt, b_lim, b_nx;
  logic [DIVW-1:0] p_cnt, p_lim, p_nx;
  logic [2:0]      byte_cnt;
  logic [1:0]      post_cnt, sel_q;
  logic            half_q, en_q;
  logic            od_tick, bit_tick, half_tick, post_tick, byte_tick, tap, pix_tick;

  assign od_nx = OCW'(((OCW+1)'(1) << od_code) - 1'b1);
  assign b_nx  = (cfg0[DIVW-1:0] == '0) ? '0 : cfg0[DIVW-1:0] - 1'b1;
  assign p_nx  = (cfg0[2*DIVW-1:DIVW] == '0) ? '0 : cfg0[2*DIVW-1:DIVW] - 1'b1;

  assign od_tick   = (od_cnt == od_lim);
  assign bit_tick  = od_tick && (b_cnt == b_lim);
  assign half_tick = bit_tick && half_q;
  assign byte_tick = bit_tick && (byte_cnt == 3'd7);
  assign post_tick = od_tick && (post_cnt == 2'd3);

  always_comb begin
    case (sel_q)
      2'd0:    tap = bit_tick;
      2'd1:    tap = half_tick;
      2'd2:    tap = od_tick;
      default: tap = post_tick;
    endcase
  end

  assign pix_tick = tap && (p_cnt == p_lim);
  assign byte_ce  = en_q && byte_tick;
  assign pix_ce   = en_q && pix_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_cnt <= '0;
      od_lim <= '0;
    end else if (od_tick) begin
      od_cnt <= '0;
      od_lim <= od_nx;
    end else begin
      od_cnt <= od_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= '0;
      b_lim <= '0;
    end else if (bit_tick) begin
      b_cnt <= '0;
      b_lim <= b_nx;
    end else if (od_tick) begin
      b_cnt <= b_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      byte_cnt <= '0;
      post_cnt <= '0;
      en_q     <= 1'b0;
    end else begin
      if (bit_tick) begin
        half_q   <= ~half_q;
        byte_cnt <= byte_cnt + 1'b1;
      end
      if (od_tick) post_cnt <= post_cnt + 1'b1;
      en_q <= cfg1[ENB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cnt <= '0;
      p_lim <= '0;
      sel_q <= '0;
    end else if (pix_tick) begin
      p_cnt <= '0;
      p_lim <= p_nx;
      sel_q <= cfg1[1:0];
    end else if (tap) begin
      p_cnt <= p_cnt + 1'b1;
    end
  end

  a_r1_od_range: assert property (@(posedge clk) disable iff (!rst_n)
    od_cnt <= od_lim);
  a_r2_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt <= b_lim);
  a_r3_byte_gap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ce |=> !byte_ce);
  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg1[ENB] |=> (!byte_ce && !pix_ce));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_tick |=> ($stable(sel_q) && $stable(p_lim)));
endmodule

// File: tb/dphy_clk_post_div_bench.sv
`timescale 1ns/1ps
module dphy_clk_post_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] od_code = 2'd0;
  logic [7:0] cfg0 = 8'h11;
  logic [7:0] cfg1 = 8'h20;
  logic       byte_ce, pix_ce;
  int total = 0, bad = 0, ecnt = 0, wd = 0;

  dphy_clk_post_div u_dphy_clk_post_div (
    .clk(clk), .rst_n(rst_n), .od_code(od_code), .cfg0(cfg0), .cfg1(cfg1),
    .byte_ce(byte_ce), .pix_ce(pix_ce));

  always #4 clk = ~clk;
  always @(posedge clk) begin
    ecnt++;
    wd++;
    if (wd > 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp<=190000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic next_pix(output int e);
    do @(negedge clk); while (!pix_ce);
    e = ecnt;
  endtask

  task automatic next_byte(output int e);
    do @(negedge clk); while (!byte_ce);
    e = ecnt;
  endtask

  function automatic int one_based(int c);
    return (c == 0) ? 1 : c;
  endfunction

  initial begin
    int e1, e2, o, b, p, tapp, seen;
    int bcodes[3] = '{0, 3, 5};
    int pcodes[3] = '{0, 1, 6};
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 byte_ce in reset", int'(byte_ce), 0);
    check("R8 pix_ce in reset", int'(pix_ce), 0);
    od_code = 2'd1; cfg0 = 8'h13; cfg1 = 8'h20;
    rst_n = 1'b1; ecnt = 0;
    next_byte(e1);
    check("R8 first byte pulse edge", e1, 7 * 2 * 3);

    // R1 R2 R3 R4 R5: sweep
    for (int oc = 0; oc < 4; oc++)
      for (int s = 0; s < 4; s++)
        for (int bi = 0; bi < 3; bi++)
          for (int pi = 0; pi < 3; pi++) begin
            @(negedge clk);
            od_code = 2'(oc);
            cfg0 = {4'(pcodes[pi]), 4'(bcodes[bi])};
            cfg1 = {2'b00, 1'b1, 3'b000, 2'(s)};
            o = 1 << oc; b = one_based(bcodes[bi]); p = one_based(pcodes[pi]);
            case (s)
              0: tapp = o * b;
              1: tapp = o * b * 2;
              2: tapp = o;
              default: tapp = o * 4;
            endcase
            next_byte(e1); next_byte(e1); next_byte(e2);
            check($sformatf("R1 R2 R3 byte period od=%0d bit=%0d", oc, bcodes[bi]),
                  e2 - e1, o * b * 8);
            next_pix(e1); next_pix(e1); next_pix(e1); next_pix(e2);
            check($sformatf("R4 R5 pix period od=%0d sel=%0d bit=%0d pix=%0d",
                  oc, s, bcodes[bi], pcodes[pi]), e2 - e1, tapp * p);
          end

    // R7: settings change inside a pixel period
    @(negedge clk);
    od_code = 2'd0; cfg0 = 8'h81; cfg1 = 8'h22;
    next_byte(e1); next_byte(e1);
    next_pix(e1); next_pix(e1); next_pix(e1);
    @(negedge clk);
    cfg0 = 8'h35; cfg1 = 8'h20;
    next_pix(e2);
    check("R7 in-progress pixel period keeps old settings", e2 - e1, 8);
    next_pix(e1); next_pix(e1); next_pix(e2);
    check("R7 new settings after wrap", e2 - e1, 15);

    // R6: global enable
    @(negedge clk);
    od_code = 2'd0; cfg0 = 8'h11; cfg1 = 8'h02;
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (byte_ce || pix_ce) seen++;
    end
    check("R6 no pulses while disabled", seen, 0);
    cfg1 = 8'h20;
    next_byte(e1); next_byte(e2);
    check("R6 byte resumes after enable", e2 - e1, 8);
    next_pix(e1); next_pix(e2);
    check("R6 pix resumes after enable", e2 - e1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule